// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block drives one pulse-width modulated output whose duty value comes from a small queue, not from a single compare register. Software writes duty values into the queue through a register port (address, write strobe, read strobe, 32-bit data). The generator takes one value at the start of every output period, so a waveform can be scheduled a few periods ahead. A status register reports how full the queue is, and a sticky flag records any write that the full queue dropped.

Counting runs from one of three tick enables, all synchronous to the single block clock: a bus-rate tick, a peripheral tick and a slow (32.768 kHz) tick. A 12-bit divider scales the selected tick down. The output period is the programmed period value plus two prescaled clocks. A self-clearing software reset returns every register to zero and empties the queue.

Top module: `fifo_pwm`

## Requirements
- R1: After reset every register reads zero and `pwm_out` is low. The offsets are control 0x00, status 0x04, sample 0x0C and period 0x10. `reg_rdata` is zero whenever `reg_rd` is low or the address matches none of these.
- R2: Control bit 0 is the enable and bits [15:4] hold the divide ratio minus one. Bits [17:16] pick the tick: 0 none, 1 `tick_bus`, 2 `tick_per`, 3 `tick_slow`. The other control bits read 0. The period register keeps bits [15:0] of the written data.
- R3: A write to control with bit 3 set clears every register and the queue. Bit 3 then reads 1 for 4 clock cycles and returns to 0. Register writes made during those cycles are ignored.
- R4: While the block is enabled, one prescaled clock occurs for every (divide ratio) ticks of the selected source.
- R5: Each sample write appends bits [15:0] to a 4-entry queue, and status bits [2:0] give the number of entries held. A sample write arriving while 4 entries are held is dropped and sets status bit 4. This holds even when an entry leaves in the same cycle.
- R6: Status bit 4 stays set until status is written with bit 4 equal to 1. A status write with bit 4 equal to 0 leaves it unchanged.
- R7: A period lasts (period register + 2) prescaled clocks. The first prescaled clock after enable starts a period. Each period start removes one queue entry, and that entry becomes the active duty.
- R8: The output is high for the first (active duty) prescaled clocks of each period. A duty of 0 gives no high time. A duty of at least (period + 2) keeps the output high.
- R9: When the queue is empty at a period start, the active duty from the previous period is used again.
- R10: While the block is disabled the output is low, the divider and period position are held at their start, and the queue keeps its entries. The next enable starts a fresh period.
- R11: A read of the sample offset returns the active duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address and state |
| tick_bus | input | 1 | Count enable at bus rate |
| tick_per | input | 1 | Count enable at peripheral rate |
| tick_slow | input | 1 | Count enable at 32.768 kHz |
| pwm_out | output | 1 | Modulated output |

## Verification
A corrupt queue count or pointer shows up in the status read at once. It reaches `pwm_out` one period later, when the wrong entry is taken or an entry is skipped. A period counter that is off by one changes the distance between rising edges in the first full period after enable. A wrong divider changes the length of every high phase. A stuck software-reset counter appears within five cycles as bit 3 still reading 1 and as writes being lost. A cycle-accurate reference model in the bench compares the output on every cycle, so any such fault is reported in the cycle where it first becomes visible.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
   // register byte offsets
   localparam int OFS_CTRL = 'h00;
   localparam int OFS_STAT = 'h04;
   localparam int OFS_SMPL = 'h0C;
   localparam int OFS_PER  = 'h10;

   // control field positions
   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_SWR_BIT = 3;
   localparam int CTRL_DIV_LSB = 4;
   localparam int CTRL_SRC_LSB = 16;

   // status field positions
   localparam int STAT_CNT_W   = 3;
   localparam int STAT_OVF_BIT = 4;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_BUS  = 2'd1,
      SRC_PER  = 2'd2,
      SRC_SLOW = 2'd3
   } src_e;
endpackage

// File: rtl/fpwm_fifo.sv
module fpwm_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   logic [W-1:0]  mem     [DEPTH];
   logic [W-1:0]  shifted [DEPTH];
   logic          pop_eff, push_eff;
   logic [CW-1:0] slot;

   if (DEPTH < 2) begin : g_bad_depth
      $error("fpwm_fifo: DEPTH must be at least 2");
   end

   // shifted view of the storage, one entry towards the head
   for (genvar g = 0; g < DEPTH; g++) begin : g_shift
      if (g == DEPTH - 1) begin : g_tail
         assign shifted[g] = '0;
      end else begin : g_body
         assign shifted[g] = mem[g+1];
      end
   end

   assign empty    = (count == '0);
   assign full     = (count == CW'(DEPTH));
   assign pop_eff  = pop && !empty;
   assign push_eff = push && !full;
   assign slot     = count - CW'(pop_eff);
   assign dout     = mem[0];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         count <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         count <= count + CW'(push_eff) - CW'(pop_eff);
         for (int i = 0; i < DEPTH; i++) begin
            if (push_eff && CW'(i) == slot) mem[i] <= din;
            else if (pop_eff)               mem[i] <= shifted[i];
         end
      end
   end
endmodule

// File: rtl/fpwm_presc.sv
module fpwm_presc #(
   parameter int DIV_W = 12,
   parameter int NSRC  = 3,
   localparam int SEL_W = $clog2(NSRC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [NSRC-1:0]  src_tick,
   input  logic [SEL_W-1:0] sel,
   input  logic [DIV_W-1:0] div,
   output logic             ptick
);
   logic [NSRC:0]    tick_vec;
   logic             tick;
   logic [DIV_W-1:0] pcnt;

   // select code 0 counts nothing; code k counts source k-1
   assign tick_vec[0] = 1'b0;
   for (genvar g = 0; g < NSRC; g++) begin : g_src
      assign tick_vec[g+1] = src_tick[g];
   end

   assign tick  = (int'(sel) <= NSRC) ? tick_vec[sel] : 1'b0;
   assign ptick = run && tick && (pcnt == div);

   always_ff @(posedge clk) begin
      if (!rst_n || clr || !run) pcnt <= '0;
      else if (tick)             pcnt <= (pcnt == div) ? '0 : pcnt + DIV_W'(1);
   end
endmodule

// File: rtl/fpwm_gen.sv
module fpwm_gen #(
   parameter int PER_W  = 16,
   parameter int DUTY_W = 16,
   localparam int CNT_W = PER_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              run,
   input  logic              ptick,
   input  logic [PER_W-1:0]  period,
   input  logic              smp_valid,
   input  logic [DUTY_W-1:0] smp,
   output logic              pop,
   output logic [DUTY_W-1:0] duty_q,
   output logic              pwm
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic             started;

   assign last = CNT_W'(period) + CNT_W'(1);
   assign pop  = ptick && (!started || cnt == last);
   assign pwm  = run && started && (32'(cnt) < 32'(duty_q));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt     <= '0;
         started <= 1'b0;
         duty_q  <= '0;
      end else if (!run) begin
         cnt     <= '0;
         started <= 1'b0;
      end else if (ptick) begin
         if (pop) begin
            cnt     <= '0;
            started <= 1'b1;
            if (smp_valid) duty_q <= smp;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/fifo_pwm.sv
module fifo_pwm
   import fpwm_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter int DIV_W   = 12,
   parameter int PER_W   = 16,
   parameter int DUTY_W  = 16,
   parameter int DEPTH   = 4,
   parameter int SWR_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tick_bus,
   input  logic              tick_per,
   input  logic              tick_slow,
   output logic              pwm_out
);
   localparam int CW   = $clog2(DEPTH + 1);
   localparam int SW   = $clog2(SWR_LEN + 1);
   localparam int NSRC = 3;

   if (DEPTH < 2 || CW > STAT_CNT_W) begin : g_bad_depth
      $error("fifo_pwm: DEPTH must lie in 2..7");
   end
   if (DIV_W < 1 || CTRL_DIV_LSB + DIV_W > CTRL_SRC_LSB) begin : g_bad_div
      $error("fifo_pwm: DIV_W must lie in 1..12");
   end
   if (PER_W > DATA_W || DUTY_W > DATA_W || DATA_W < CTRL_SRC_LSB + 2) begin : g_bad_w
      $error("fifo_pwm: field widths exceed the data bus");
   end
   if (SWR_LEN < 1) begin : g_bad_swr
      $error("fifo_pwm: SWR_LEN must be positive");
   end

   logic              en_q;
   logic [DIV_W-1:0]  div_q;
   src_e              src_q;
   logic [PER_W-1:0]  per_q;
   logic              ovf_q;
   logic [SW-1:0]     swr_cnt;
   logic              swr_busy, wr_ok, swr_go, clr;
   logic              hit_ctrl, hit_stat, hit_smpl, hit_per;
   logic              ptick, pop;
   logic [DUTY_W-1:0] fifo_dout, duty_q;
   logic [CW-1:0]     fifo_cnt;
   logic              fifo_empty, fifo_full;
   logic              unused_wdata;

   assign unused_wdata = ^reg_wdata;

   assign hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
   assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
   assign hit_smpl = (reg_addr == ADDR_W'(OFS_SMPL));
   assign hit_per  = (reg_addr == ADDR_W'(OFS_PER));

   assign swr_busy = (swr_cnt != '0);
   assign wr_ok    = reg_wr && !swr_busy;
   assign swr_go   = wr_ok && hit_ctrl && reg_wdata[CTRL_SWR_BIT];
   assign clr      = swr_busy || swr_go;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         div_q   <= '0;
         src_q   <= SRC_NONE;
         per_q   <= '0;
         ovf_q   <= 1'b0;
         swr_cnt <= '0;
      end else if (clr) begin
         en_q    <= 1'b0;
         div_q   <= '0;
         src_q   <= SRC_NONE;
         per_q   <= '0;
         ovf_q   <= 1'b0;
         swr_cnt <= swr_busy ? swr_cnt - SW'(1) : SW'(SWR_LEN);
      end else begin
         if (wr_ok && hit_ctrl) begin
            en_q  <= reg_wdata[CTRL_EN_BIT];
            div_q <= reg_wdata[CTRL_DIV_LSB +: DIV_W];
            src_q <= src_e'(reg_wdata[CTRL_SRC_LSB +: 2]);
         end
         if (wr_ok && hit_per) per_q <= reg_wdata[PER_W-1:0];
         if (wr_ok && hit_smpl && fifo_full)                ovf_q <= 1'b1;
         else if (wr_ok && hit_stat && reg_wdata[STAT_OVF_BIT]) ovf_q <= 1'b0;
      end
   end

   fpwm_presc #(.DIV_W(DIV_W), .NSRC(NSRC)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .run      (en_q),
      .src_tick ({tick_slow, tick_per, tick_bus}),
      .sel      (src_q),
      .div      (div_q),
      .ptick    (ptick)
   );

   fpwm_fifo #(.DEPTH(DEPTH), .W(DUTY_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (wr_ok && hit_smpl),
      .pop   (pop),
      .din   (reg_wdata[DUTY_W-1:0]),
      .dout  (fifo_dout),
      .count (fifo_cnt),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   fpwm_gen #(.PER_W(PER_W), .DUTY_W(DUTY_W)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .run       (en_q),
      .ptick     (ptick),
      .period    (per_q),
      .smp_valid (!fifo_empty),
      .smp       (fifo_dout),
      .pop       (pop),
      .duty_q    (duty_q),
      .pwm       (pwm_out)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         if (hit_ctrl)
            reg_rdata = (DATA_W'(en_q)     << CTRL_EN_BIT)
                      | (DATA_W'(swr_busy) << CTRL_SWR_BIT)
                      | (DATA_W'(div_q)    << CTRL_DIV_LSB)
                      | (DATA_W'(src_q)    << CTRL_SRC_LSB);
         else if (hit_stat)
            reg_rdata = DATA_W'(fifo_cnt) | (DATA_W'(ovf_q) << STAT_OVF_BIT);
         else if (hit_smpl)
            reg_rdata = DATA_W'(duty_q);
         else if (hit_per)
            reg_rdata = DATA_W'(per_q);
      end
   end
endmodule

// File: rtl/fifo_pwm_chk.sv
module fifo_pwm_chk
   import fpwm_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DEPTH  = 4,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr,
   input logic [ADDR_W-1:0] addr,
   input logic              w_swr,
   input logic              w_ovf,
   input logic              pwm,
   input logic              en,
   input logic [CW-1:0]     cnt,
   input logic              ovf,
   input logic              busy
);
   // R10: disabled output is low
   p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !pwm);

   // R5: occupancy never exceeds depth
   p_fifo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) <= DEPTH);

   // R5: a write into a full queue raises the overflow flag
   p_drop_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !busy && addr == ADDR_W'(OFS_SMPL) && 32'(cnt) == DEPTH) |=> ovf);

   // R6: the flag only falls on a write-one clear or a software reset
   p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !busy && !(wr && addr == ADDR_W'(OFS_STAT) && w_ovf)
           && !(wr && addr == ADDR_W'(OFS_CTRL) && w_swr)) |=> ovf);

   // R3: during software reset the queue is empty and the block is idle
   p_swr_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt == '0 && !ovf && !en && !pwm));

   // R3: the reset ends with the block disabled
   p_swr_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !en);
endmodule

bind fifo_pwm fifo_pwm_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr    (reg_wr),
   .addr  (reg_addr),
   .w_swr (reg_wdata[3]),
   .w_ovf (reg_wdata[4]),
   .pwm   (pwm_out),
   .en    (en_q),
   .cnt   (fifo_cnt),
   .ovf   (ovf_q),
   .busy  (swr_busy)
);

// File: tb/fifo_pwm_tb.sv
`timescale 1ns/1ps
module fifo_pwm_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        t_bus = 1'b1, t_per = 1'b0, t_slow = 1'b0;
   logic        pwm_out;
   logic        rnd_ticks = 1'b0;

   int    checks = 0, errors = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // reference model state
   int m_en, m_div, m_src, m_per, m_ovf, m_busy, m_pcnt, m_started, m_cnt, m_duty, m_n;
   int mq [4];

   always #5 clk = ~clk;

   fifo_pwm u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
      .reg_wdata(wdata), .reg_rdata(rdata), .tick_bus(t_bus), .tick_per(t_per),
      .tick_slow(t_slow), .pwm_out(pwm_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic void m_clear();
      m_en = 0; m_div = 0; m_src = 0; m_per = 0; m_ovf = 0; m_pcnt = 0;
      m_started = 0; m_cnt = 0; m_duty = 0; m_n = 0;
      for (int i = 0; i < 4; i++) mq[i] = 0;
   endfunction

   function automatic int m_read(input int a);
      case (a)
         'h00: return m_en | ((m_busy != 0) ? 8 : 0) | (m_div << 4) | (m_src << 16);
         'h04: return m_n | (m_ovf << 4);
         'h0C: return m_duty;
         'h10: return m_per;
         default: return 0;
      endcase
   endfunction

   function automatic bit m_pwm();
      return (m_en != 0) && (m_started != 0) && (m_cnt < m_duty);
   endfunction

   // model built from the requirements, advanced at each clock edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_clear(); m_busy = 0;
      end else begin
         int  old_n;
         bit  tick, ptk, pop;
         tick = (m_src == 1) ? t_bus : (m_src == 2) ? t_per : (m_src == 3) ? t_slow : 1'b0;
         ptk  = (m_en != 0) && tick && (m_pcnt == m_div);
         pop  = ptk && (m_started == 0 || m_cnt == m_per + 1);
         if (m_busy != 0) begin
            m_clear(); m_busy--;
         end else if (wr && addr == 5'h00 && wdata[3]) begin
            m_clear(); m_busy = 4;
         end else begin
            old_n = m_n;
            if (m_en == 0) begin
               m_pcnt = 0; m_started = 0; m_cnt = 0;
            end else begin
               if (tick) m_pcnt = (m_pcnt == m_div) ? 0 : m_pcnt + 1;
               if (ptk) begin
                  if (pop) begin m_cnt = 0; m_started = 1; end
                  else m_cnt++;
               end
            end
            if (pop && old_n > 0) begin
               m_duty = mq[0];
               for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
               mq[3] = 0; m_n--;
            end
            if (wr && addr == 5'h0C) begin
               if (old_n == 4) m_ovf = 1;
               else begin mq[m_n] = int'(wdata[15:0]); m_n++; end
            end
            if (wr && addr == 5'h04 && wdata[4]) m_ovf = 0;
            if (wr && addr == 5'h00) begin
               m_en = int'(wdata[0]); m_div = int'(wdata[15:4]); m_src = int'(wdata[17:16]);
            end
            if (wr && addr == 5'h10) m_per = int'(wdata[15:0]);
         end
      end
   end

   // compare outputs against the model between edges
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, 32'(pwm_out), 32'(m_pwm()));
         if (rd) chk(cur_req, rdata, m_read(int'(addr)));
      end
   end

   // tick sources
   always @(posedge clk) begin
      #2;
      if (rnd_ticks) begin
         t_bus  = ($urandom % 4) != 0;
         t_per  = ($urandom % 3) == 0;
         t_slow = ($urandom % 7) == 0;
      end else begin
         t_bus = 1'b1; t_per = ($urandom % 2) == 0; t_slow = 1'b0;
      end
   end

   task automatic wreg(input logic [4:0] a, input logic [31:0] d);
      @(posedge clk); #2; wr = 1'b1; rd = 1'b0; addr = a; wdata = d;
      @(posedge clk); #2; wr = 1'b0;
   endtask

   task automatic rreg(input logic [4:0] a, output logic [31:0] v);
      @(posedge clk); #2; rd = 1'b1; wr = 1'b0; addr = a;
      @(negedge clk); v = rdata;
      @(posedge clk); #2; rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   // rising edge to rising edge: period length and high time in cycles
   task automatic measure(output int hi, output int per);
      logic p;
      int   lim;
      @(negedge clk); p = pwm_out; lim = 0;
      while (!(!p && pwm_out) && lim < 400) begin
         p = pwm_out; @(negedge clk); lim++;
      end
      hi = 0; per = 0;
      do begin
         if (pwm_out) hi++;
         per++; p = pwm_out;
         @(negedge clk);
      end while (!(!p && pwm_out) && per < 400);
   endtask

   task automatic level_for(input string req, input int n, input logic lvl);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); chk(req, 32'(pwm_out), 32'(lvl));
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      checks++; errors++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int hi, per;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: reset state
      cur_req = "R1";
      @(negedge clk); chk("R1 pwm", 32'(pwm_out), 0);
      chk("R1 idle rdata", rdata, 0);
      rreg(5'h00, v); chk("R1 ctrl", v, 0);
      rreg(5'h04, v); chk("R1 stat", v, 0);
      rreg(5'h0C, v); chk("R1 smpl", v, 0);
      rreg(5'h10, v); chk("R1 per", v, 0);
      rreg(5'h08, v); chk("R1 hole", v, 0);

      // R2: field readback, junk bits dropped
      cur_req = "R2";
      wreg(5'h00, 32'hFFF2_0052);
      rreg(5'h00, v); chk("R2 ctrl", v, 32'h0002_0050);
      wreg(5'h10, 32'hFFFF_1234);
      rreg(5'h10, v); chk("R2 per", v, 32'h1234);

      // R5/R6: fill, overflow, write-one clear
      cur_req = "R5";
      for (int i = 0; i < 4; i++) wreg(5'h0C, 32'(i + 1));
      rreg(5'h04, v); chk("R5 full", v, 4);
      wreg(5'h0C, 32'd9);
      rreg(5'h04, v); chk("R5 drop", v, 32'h14);
      cur_req = "R6";
      wreg(5'h04, 32'h0000_000F);
      rreg(5'h04, v); chk("R6 zero write", v, 32'h14);
      wreg(5'h04, 32'h10);
      rreg(5'h04, v); chk("R6 clear", v, 4);

      // R3: software reset
      cur_req = "R3";
      wreg(5'h00, 32'h8);
      wreg(5'h10, 32'h7);
      rreg(5'h00, v); chk("R3 busy bit", v, 32'h8);
      idle(4);
      rreg(5'h00, v); chk("R3 self clear", v, 0);
      rreg(5'h10, v); chk("R3 write ignored", v, 0);
      rreg(5'h04, v); chk("R3 flush", v, 0);

      // R7/R8: period and duty
      cur_req = "R7";
      wreg(5'h10, 32'd3);
      for (int i = 0; i < 3; i++) wreg(5'h0C, 32'd2);
      wreg(5'h00, 32'h0001_0001);
      measure(hi, per);
      chk("R7 period", 32'(per), 5);
      chk("R8 high", 32'(hi), 2);

      // R9: repeat after the queue drains
      cur_req = "R9";
      idle(30);
      rreg(5'h04, v); chk("R9 drained", v, 0);
      measure(hi, per);
      chk("R9 repeat high", 32'(hi), 2);
      cur_req = "R11";
      rreg(5'h0C, v); chk("R11 active", v, 2);

      // R8: extremes
      cur_req = "R8";
      wreg(5'h0C, 32'd0);
      idle(12);
      level_for("R8 zero duty", 10, 1'b0);
      wreg(5'h0C, 32'd9);
      idle(12);
      level_for("R8 full duty", 10, 1'b1);

      // R10: disable
      cur_req = "R10";
      wreg(5'h00, 32'h0001_0000);
      level_for("R10 low", 10, 1'b0);
      wreg(5'h0C, 32'd4);
      wreg(5'h0C, 32'd1);
      idle(20);
      rreg(5'h04, v); chk("R10 kept", v, 2);
      rreg(5'h0C, v); chk("R11 held", v, 9);
      wreg(5'h00, 32'h0001_0001);
      measure(hi, per);
      chk("R10 restart", 32'(per), 5);

      // R4: prescaler divide by 4
      cur_req = "R4";
      wreg(5'h00, 32'h8);
      idle(5);
      wreg(5'h10, 32'd0);
      wreg(5'h0C, 32'd1);
      wreg(5'h00, 32'h0001_0031);
      measure(hi, per);
      chk("R4 period", 32'(per), 8);
      chk("R4 high", 32'(hi), 4);

      // random traffic against the model
      cur_req = "R7";
      rnd_ticks = 1'b1;
      for (int k = 0; k < 4000; k++) begin
         int r;
         r = int'($urandom % 16);
         if (r < 6) idle(1);
         else if (r < 9) wreg(5'h0C, {$urandom} & 32'hFFF0_0000 | 32'($urandom % 10));
         else if (r == 9) wreg(5'h10, {$urandom} & 32'hFFFF_0000 | 32'($urandom % 7));
         else if (r == 10)
            wreg(5'h00, ({$urandom} & 32'hFFFC_0006)
                        | 32'(($urandom % 4) != 0)
                        | (32'(($urandom % 17) == 0) << 3)
                        | (32'($urandom % 4) << 4)
                        | (32'($urandom % 4) << 16));
         else if (r == 11) wreg(5'h04, {$urandom});
         else begin
            logic [4:0] a;
            case ($urandom % 5)
               0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h0C; 3: a = 5'h10; default: a = 5'h14;
            endcase
            rreg(a, v);
         end
      end
      idle(4);
      finish_run();
   end
endmodule